// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 44 maskable peripheral request lines and four exception inputs. It decides which one, if any, may interrupt the processor core. Each maskable source has three registered controls: a sticky request flag, an enable bit and a 3-bit priority. The controller picks the strongest eligible request and compares its priority with the core's current 4-bit priority level. When the request may preempt, the controller raises a registered request that carries a 6-bit vector number and the new level.

The core answers with an acknowledge pulse. On that pulse the current level is saved on a small level stack and replaced by the level of the accepted request, and the vector and level are latched into a status word. A return pulse restores the saved level. Software reaches every control through a simple single-cycle write / registered-read bus.

The bus also sets three more controls. A nesting-disable mode blocks all maskable requests while any interrupt is in service, and it freezes the level register against software writes. A counted masking window, started by a bus write, suppresses priorities 6 and below until the core has retired the programmed number of instructions. An alternate-table select bit is passed to the core.

Top module: `prio_vec_intc`

## Requirements
- R1: Source j's request flag is bit j%16 of the word at address j/16 (addresses 0..2). It sets on a `src_evt` pulse whatever its enable bit holds. Writing 1 to the bit clears it. When a set and a clear land in the same cycle, the set wins.
- R2: A source whose 3-bit priority is 0 is never requested, even when it is flagged and enabled. Source j's priority is in bits [4*(j%4)+2 : 4*(j%4)] of address 8 + j/4. Its enable is bit j%16 of address 4 + j/16.
- R3: A maskable source is requested only when it is flagged, enabled and its priority is strictly above the current level (address 21, bits 3:0).
- R4: Among eligible maskable sources the highest priority wins, and on a tie the lowest source index wins. Source j uses vector 8 + j. `irq_req`, `irq_vec` and `irq_lvl` are registered one cycle after the state they come from, and `irq_req` is low in the cycle after an accepted acknowledge.
- R5: A pulse on exception input i sets an exception flag (readable at address 3, bit i). The flag is requested with vector i and fixed level 15 - i whenever that level is above the current level, even inside the masking window or under nesting-disable. Acknowledging it clears the flag.
- R6: When `irq_ack` is high while `irq_req` is high, the current level is pushed and then set to `irq_lvl`. Address 22 then reads the vector in bits 5:0 and the level in bits 11:8.
- R7: A pulse on `irq_ret` with a non-empty level stack restores the most recently pushed level. With an empty stack the pulse has no effect.
- R8: With the nesting-disable bit (address 20, bit 15) set, no maskable source is requested while an interrupt is in service, and writes to the level register are ignored.
- R9: Writing N to address 23 masks priorities 1..6 until N `instr_retire` pulses have passed. Address 20 bit 14 stays high for exactly that span, address 23 reads the remaining count, and priority 7 stays eligible.
- R10: Address 20 bit 13 selects the alternate vector table and appears on `irq_alt` one cycle after it is written.
- R11: After reset all flags, enables, priorities, controls, the level and the status word are zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the address of the previous cycle |
| src_evt | input | 44 | Maskable source event pulses |
| trap_evt | input | 4 | Exception event pulses |
| instr_retire | input | 1 | One pulse per retired instruction |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from an interrupt |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 6 | Vector number of the request |
| irq_lvl | output | 4 | Priority level of the request |
| irq_alt | output | 1 | Alternate vector table select |

## Verification
A wrong flag, enable or priority bit shows up as a wrong or missing `irq_vec` or `irq_lvl` one cycle after the stored state changes. A corrupted level or stack entry shows up as a request that is wrongly raised or withheld, in the cycle after the acknowledge or return that used it. A stuck masking-window counter keeps mid-priority requests away well beyond the retire count, and the window bit in the control word reveals this on the next read. Since every stored field can be read back one cycle after its address is presented, the bench compares the whole register image and the request outputs against a behavioural model on every clock.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DW      = 16;
  localparam int AW      = 5;
  localparam int VEC_W   = 6;
  localparam int LVL_W   = 4;
  // register word addresses
  localparam int A_FLAG0 = 0;
  localparam int A_TRAP  = 3;
  localparam int A_EN0   = 4;
  localparam int A_PRIO0 = 8;
  localparam int A_CTRL  = 20;
  localparam int A_LVL   = 21;
  localparam int A_STAT  = 22;
  localparam int A_WIN   = 23;
  // control word bit positions
  localparam int B_NEST  = 15;
  localparam int B_WIN   = 14;
  localparam int B_ALT   = 13;
  // priority fields per word and field pitch
  localparam int PF_PER_W = 4;
  localparam int PF_PITCH = 4;

  typedef struct packed {
    logic             vld;
    logic [VEC_W-1:0] vec;
    logic [LVL_W-1:0] lvl;
  } irq_sel_t;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC  = 44,
  parameter int NTRAP = 4,
  parameter int PW    = 3,
  parameter int WCW   = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [DW-1:0]             wdata,
  input  logic [NSRC-1:0]           src_evt,
  input  logic [NTRAP-1:0]          trap_evt,
  input  logic [NTRAP-1:0]          trap_clr,
  input  logic                      retire,
  output logic [NSRC-1:0]           flags,
  output logic [NSRC-1:0]           en,
  output logic [NSRC-1:0][PW-1:0]   prio,
  output logic [NTRAP-1:0]          trap_flags,
  output logic                      nest_dis,
  output logic                      alt_sel,
  output logic                      win_active,
  output logic [WCW-1:0]            win_cnt
);
  logic win_cmd;
  assign win_cmd    = we && (addr == AW'(A_WIN));
  assign win_active = (win_cnt != '0);

  for (genvar j = 0; j < NSRC; j++) begin : g_src
    localparam int WORD = j / DW;
    localparam int BIT  = j % DW;
    localparam int PWRD = j / PF_PER_W;
    localparam int PLSB = PF_PITCH * (j % PF_PER_W);
    logic clr;
    assign clr = we && (addr == AW'(A_FLAG0 + WORD)) && wdata[BIT];

    always_ff @(posedge clk) begin
      if (rst) begin
        flags[j] <= 1'b0;
        en[j]    <= 1'b0;
        prio[j]  <= '0;
      end else begin
        flags[j] <= (flags[j] && !clr) || src_evt[j];
        if (we && (addr == AW'(A_EN0 + WORD)))
          en[j] <= wdata[BIT];
        if (we && (addr == AW'(A_PRIO0 + PWRD)))
          prio[j] <= wdata[PLSB +: PW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_flags <= '0;
      nest_dis   <= 1'b0;
      alt_sel    <= 1'b0;
      win_cnt    <= '0;
    end else begin
      trap_flags <= (trap_flags & ~trap_clr) | trap_evt;
      if (we && (addr == AW'(A_CTRL))) begin
        nest_dis <= wdata[B_NEST];
        alt_sel  <= wdata[B_ALT];
      end
      if (win_cmd)
        win_cnt <= wdata[WCW-1:0];
      else if (retire && win_active)
        win_cnt <= win_cnt - 1'b1;
    end
  end

  a_r1_flag_sets: assert property (@(posedge clk) disable iff (rst)
    (src_evt != '0) |=> ((flags & $past(src_evt)) == $past(src_evt)));
  a_r9_window_holds: assert property (@(posedge clk) disable iff (rst)
    (win_active && !retire && !win_cmd) |=> win_active);
  a_r5_trap_sets: assert property (@(posedge clk) disable iff (rst)
    (trap_evt != '0) |=> ((trap_flags & $past(trap_evt)) == $past(trap_evt)));
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int NSRC     = 44,
  parameter int NTRAP    = 4,
  parameter int PW       = 3,
  parameter int VEC_BASE = 8,
  parameter int WIN_TOP  = 6
) (
  input  logic [NSRC-1:0]         flags,
  input  logic [NSRC-1:0]         en,
  input  logic [NSRC-1:0][PW-1:0] prio,
  input  logic [NTRAP-1:0]        trap_flags,
  input  logic [LVL_W-1:0]        cpu_lvl,
  input  logic                    win_active,
  input  logic                    nest_blk,
  output irq_sel_t                sel
);
  localparam int TOP_LVL = (1 << LVL_W) - 1;

  logic [NSRC-1:0] elig;
  for (genvar j = 0; j < NSRC; j++) begin : g_elig
    assign elig[j] = flags[j] && en[j] && (prio[j] != '0)
                  && (LVL_W'(prio[j]) > cpu_lvl)
                  && !(win_active && (int'(prio[j]) <= WIN_TOP))
                  && !nest_blk;
  end

  logic [NTRAP-1:0] t_elig;
  for (genvar i = 0; i < NTRAP; i++) begin : g_telig
    assign t_elig[i] = trap_flags[i] && (LVL_W'(TOP_LVL - i) > cpu_lvl);
  end

  logic [PW-1:0] best_p;
  logic [VEC_W-1:0] best_v;
  logic          found;
  logic [VEC_W-1:0] t_v;
  logic          t_found;

  always_comb begin
    best_p = '0;
    best_v = '0;
    found  = 1'b0;
    for (int j = NSRC - 1; j >= 0; j--) begin
      if (elig[j] && (prio[j] >= best_p)) begin
        best_p = prio[j];
        best_v = VEC_W'(VEC_BASE + j);
        found  = 1'b1;
      end
    end
    t_v     = '0;
    t_found = 1'b0;
    for (int i = NTRAP - 1; i >= 0; i--) begin
      if (t_elig[i]) begin
        t_v     = VEC_W'(i);
        t_found = 1'b1;
      end
    end
  end

  always_comb begin
    sel = '0;
    if (t_found) begin
      sel.vld = 1'b1;
      sel.vec = t_v;
      sel.lvl = LVL_W'(TOP_LVL) - LVL_W'(t_v);
    end else if (found) begin
      sel.vld = 1'b1;
      sel.vec = best_v;
      sel.lvl = LVL_W'(best_p);
    end
  end
endmodule

// File: rtl/intc_lvl.sv
module intc_lvl
  import intc_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [LVL_W-1:0] new_lvl,
  input  logic             ret,
  input  logic             sw_we,
  input  logic [LVL_W-1:0] sw_lvl,
  input  logic             nest_dis,
  output logic [LVL_W-1:0] cpu_lvl,
  output logic             in_service
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [LVL_W-1:0] stk [DEPTH];
  logic [SPW-1:0]   sp;
  logic             full;
  logic [IW-1:0]    top_idx;

  assign full       = (sp == SPW'(DEPTH));
  assign in_service = (sp != '0);
  assign top_idx    = IW'(sp - 1'b1);

  always_ff @(posedge clk) begin
    if (take && !full)
      stk[sp[IW-1:0]] <= cpu_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_lvl <= '0;
      sp      <= '0;
    end else if (take) begin
      cpu_lvl <= new_lvl;
      if (!full) sp <= sp + 1'b1;
    end else if (ret && in_service) begin
      cpu_lvl <= stk[top_idx];
      sp      <= sp - 1'b1;
    end else if (sw_we && !nest_dis) begin
      cpu_lvl <= sw_lvl;
    end
  end

  a_r6_take_raises: assert property (@(posedge clk) disable iff (rst)
    take |=> (cpu_lvl == $past(new_lvl)));
  a_r8_level_locked: assert property (@(posedge clk) disable iff (rst)
    (sw_we && nest_dis && !take && !ret) |=> $stable(cpu_lvl));
  a_r7_empty_ret: assert property (@(posedge clk) disable iff (rst)
    (ret && !in_service && !take && !sw_we) |=> $stable(cpu_lvl));
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
#(
  parameter int NSRC     = 44,
  parameter int NTRAP    = 4,
  parameter int PW       = 3,
  parameter int VEC_BASE = 8,
  parameter int WIN_TOP  = 6,
  parameter int STK_D    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_evt,
  input  logic [NTRAP-1:0]  trap_evt,
  input  logic              instr_retire,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_req,
  output logic [5:0]        irq_vec,
  output logic [3:0]        irq_lvl,
  output logic              irq_alt
);
  localparam int NFW  = (NSRC + DW - 1) / DW;
  localparam int FPW  = NFW * DW;
  localparam int NPRW = (NSRC + PF_PER_W - 1) / PF_PER_W;
  localparam int NPF  = NPRW * PF_PER_W;

  logic [NSRC-1:0]         flags, en;
  logic [NSRC-1:0][PW-1:0] prio;
  logic [NTRAP-1:0]        trap_flags, trap_clr;
  logic                    nest_dis, alt_sel, win_active, in_service, take;
  logic [DW-1:0]           win_cnt;
  logic [LVL_W-1:0]        cpu_lvl;
  logic [VEC_W-1:0]        stat_vec;
  logic [LVL_W-1:0]        stat_lvl;
  irq_sel_t                sel;

  assign take = irq_ack && irq_req;

  for (genvar i = 0; i < NTRAP; i++) begin : g_tclr
    assign trap_clr[i] = take && (irq_vec == VEC_W'(i));
  end

  intc_regs #(.NSRC(NSRC), .NTRAP(NTRAP), .PW(PW), .WCW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .src_evt(src_evt), .trap_evt(trap_evt), .trap_clr(trap_clr),
    .retire(instr_retire), .flags(flags), .en(en), .prio(prio),
    .trap_flags(trap_flags), .nest_dis(nest_dis), .alt_sel(alt_sel),
    .win_active(win_active), .win_cnt(win_cnt)
  );

  intc_arb #(.NSRC(NSRC), .NTRAP(NTRAP), .PW(PW), .VEC_BASE(VEC_BASE),
             .WIN_TOP(WIN_TOP)) u_arb (
    .flags(flags), .en(en), .prio(prio), .trap_flags(trap_flags),
    .cpu_lvl(cpu_lvl), .win_active(win_active),
    .nest_blk(nest_dis && in_service), .sel(sel)
  );

  intc_lvl #(.DEPTH(STK_D)) u_lvl (
    .clk(clk), .rst(rst), .take(take), .new_lvl(irq_lvl), .ret(irq_ret),
    .sw_we(bus_we && (bus_addr == AW'(A_LVL))),
    .sw_lvl(bus_wdata[LVL_W-1:0]), .nest_dis(nest_dis),
    .cpu_lvl(cpu_lvl), .in_service(in_service)
  );

  // padded views for the readback mux
  logic [FPW-1:0] flag_pad, en_pad;
  logic [NPF-1:0][PW-1:0] prio_pad;
  assign flag_pad = FPW'(flags);
  assign en_pad   = FPW'(en);
  for (genvar k = 0; k < NPF; k++) begin : g_ppad
    if (k < NSRC) begin : g_real
      assign prio_pad[k] = prio[k];
    end else begin : g_zero
      assign prio_pad[k] = '0;
    end
  end

  logic [DW-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int w = 0; w < NFW; w++) begin
      if (bus_addr == AW'(A_FLAG0 + w)) rd_next = flag_pad[w*DW +: DW];
      if (bus_addr == AW'(A_EN0 + w))   rd_next = en_pad[w*DW +: DW];
    end
    for (int w = 0; w < NPRW; w++) begin
      if (bus_addr == AW'(A_PRIO0 + w))
        for (int k = 0; k < PF_PER_W; k++)
          rd_next[PF_PITCH*k +: PW] = prio_pad[w*PF_PER_W + k];
    end
    if (bus_addr == AW'(A_TRAP)) rd_next = DW'(trap_flags);
    if (bus_addr == AW'(A_CTRL)) begin
      rd_next[B_NEST] = nest_dis;
      rd_next[B_WIN]  = win_active;
      rd_next[B_ALT]  = alt_sel;
    end
    if (bus_addr == AW'(A_LVL))  rd_next = DW'(cpu_lvl);
    if (bus_addr == AW'(A_STAT)) rd_next = DW'({stat_lvl, 2'b00, stat_vec});
    if (bus_addr == AW'(A_WIN))  rd_next = win_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      irq_lvl   <= '0;
      irq_alt   <= 1'b0;
      bus_rdata <= '0;
      stat_vec  <= '0;
      stat_lvl  <= '0;
    end else begin
      irq_req   <= sel.vld && !take;
      irq_vec   <= sel.vec;
      irq_lvl   <= sel.lvl;
      irq_alt   <= alt_sel;
      bus_rdata <= rd_next;
      if (take) begin
        stat_vec <= irq_vec;
        stat_lvl <= irq_lvl;
      end
    end
  end

  a_r4_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    take |=> !irq_req);
  a_r5_trap_level: assert property (@(posedge clk) disable iff (rst)
    (irq_req && (irq_vec < VEC_W'(NTRAP))) |-> (irq_lvl == 4'(15 - irq_vec)));
  a_r2_no_zero_level: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_lvl != '0));
  a_r6_status_latch: assert property (@(posedge clk) disable iff (rst)
    take |=> (stat_vec == $past(irq_vec) && stat_lvl == $past(irq_lvl)));
endmodule

// File: tb/test_prio_vec_intc.sv
module test_prio_vec_intc;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [43:0] src_evt = '0;
  logic [3:0] trap_evt = '0;
  logic instr_retire = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic irq_req, irq_alt;
  logic [5:0] irq_vec;
  logic [3:0] irq_lvl;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_vec_intc i_prio_vec_intc (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
    .trap_evt(trap_evt), .instr_retire(instr_retire), .irq_ack(irq_ack),
    .irq_ret(irq_ret), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_lvl(irq_lvl), .irq_alt(irq_alt)
  );

  int total = 0, fails = 0;
  string cur_tag = "R11";
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit mf[44], men[44], mt[4];
  int mp[44];
  int mlvl, mwin, mst_vec, mst_lvl;
  bit mnest, malt;
  int stk[$];
  bit exp_req, exp_alt;
  int exp_vec, exp_lvl, exp_rd;

  function automatic int mread(int a);
    int v = 0;
    if (a <= 2 || (a >= 4 && a <= 6)) begin
      for (int b = 0; b < 16; b++) begin
        int s = (a % 4) * 16 + b;
        if (s < 44 && ((a < 3) ? mf[s] : men[s])) v |= (1 << b);
      end
    end else if (a == 3) begin
      for (int i = 0; i < 4; i++) if (mt[i]) v |= (1 << i);
    end else if (a >= 8 && a <= 18) begin
      for (int k = 0; k < 4; k++) begin
        int s = (a - 8) * 4 + k;
        if (s < 44) v |= mp[s] << (4 * k);
      end
    end else if (a == 20) v = (int'(mnest) << 15) | (int'(mwin > 0) << 14) | (int'(malt) << 13);
    else if (a == 21) v = mlvl;
    else if (a == 22) v = (mst_lvl << 8) | mst_vec;
    else if (a == 23) v = mwin;
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (mf[j]) begin mf[j] = 0; men[j] = 0; mp[j] = 0; end
      foreach (mt[i]) mt[i] = 0;
      mlvl = 0; mwin = 0; mst_vec = 0; mst_lvl = 0; mnest = 0; malt = 0;
      stk.delete();
      exp_req = 0; exp_alt = 0; exp_vec = 0; exp_lvl = 0; exp_rd = 0;
    end else begin
      bit take, found;
      int nv, nl, a, d;
      take = irq_ack && exp_req;
      found = 0; nv = 0; nl = 0;
      for (int i = 0; i < 4 && !found; i++)
        if (mt[i] && (15 - i) > mlvl) begin found = 1; nv = i; nl = 15 - i; end
      if (!found)
        for (int j = 0; j < 44; j++)
          if (mf[j] && men[j] && mp[j] > 0 && mp[j] > mlvl && !(mwin > 0 && mp[j] <= 6)
              && !(mnest && stk.size() > 0) && mp[j] > nl) begin
            found = 1; nv = 8 + j; nl = mp[j];
          end
      a = bus_addr; d = bus_wdata;
      exp_rd = mread(a);
      exp_alt = malt;
      // state updates
      if (take) begin
        mst_vec = exp_vec; mst_lvl = exp_lvl;
        if (exp_vec < 4) mt[exp_vec] = 0;
      end
      if (bus_we && a <= 2)
        for (int b = 0; b < 16; b++) if (a*16+b < 44 && d[b]) mf[a*16+b] = 0;
      for (int j = 0; j < 44; j++) if (src_evt[j]) mf[j] = 1;
      for (int i = 0; i < 4; i++) if (trap_evt[i]) mt[i] = 1;
      if (bus_we && a >= 4 && a <= 6)
        for (int b = 0; b < 16; b++) if ((a-4)*16+b < 44) men[(a-4)*16+b] = d[b];
      if (bus_we && a >= 8 && a <= 18)
        for (int k = 0; k < 4; k++) if ((a-8)*4+k < 44) mp[(a-8)*4+k] = (d >> (4*k)) & 7;
      if (take) begin
        if (stk.size() < 16) stk.push_back(mlvl);
        mlvl = exp_lvl;
      end else if (irq_ret && stk.size() > 0) mlvl = stk.pop_back();
      else if (bus_we && a == 21 && !mnest) mlvl = d & 15;
      if (bus_we && a == 20) begin mnest = d[15]; malt = d[13]; end
      if (bus_we && a == 23) mwin = d;
      else if (instr_retire && mwin > 0) mwin--;
      exp_req = found && !take; exp_vec = nv; exp_lvl = nl;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq_req == exp_req, {cur_tag, " req"}, irq_req, exp_req);
      if (exp_req) begin
        chk(irq_vec == exp_vec, {cur_tag, " vec"}, irq_vec, exp_vec);
        chk(irq_lvl == exp_lvl, {cur_tag, " lvl"}, irq_lvl, exp_lvl);
      end
      chk(irq_alt == exp_alt, "R10 alt", irq_alt, exp_alt);
      chk(bus_rdata == exp_rd, {cur_tag, " rdata"}, bus_rdata, exp_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(int a, int d);
    @(negedge clk); bus_we = 1; bus_addr = 5'(a); bus_wdata = 16'(d);
    @(negedge clk); bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask
  task automatic rd(int a, output int v);
    @(negedge clk); bus_addr = 5'(a);
    @(negedge clk); v = bus_rdata; bus_addr = 0;
  endtask
  task automatic evt(int j);
    @(negedge clk); src_evt[j] = 1;
    @(negedge clk); src_evt = '0;
  endtask
  task automatic pulse_ack();
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask
  task automatic pulse_ret();
    @(negedge clk); irq_ret = 1;
    @(negedge clk); irq_ret = 0;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    cur_tag = "R11";
    rd(21, v); chk(v == 0, "R11 level", v, 0);
    rd(20, v); chk(v == 0, "R11 ctrl", v, 0);
    chk(irq_req == 0, "R11 req", irq_req, 0);
    // R1 flag sets without enable; W1C; set wins
    cur_tag = "R1";
    evt(5); rd(0, v); chk(v == 16'h0020, "R1 flag", v, 16'h0020);
    wr(0, 16'h0020); rd(0, v); chk(v == 0, "R1 clear", v, 0);
    @(negedge clk); bus_we = 1; bus_addr = 0; bus_wdata = 16'h0040; src_evt[6] = 1;
    @(negedge clk); bus_we = 0; bus_wdata = 0; src_evt = '0;
    rd(0, v); chk(v == 16'h0040, "R1 set wins", v, 16'h0040);
    // R2 priority zero never taken
    cur_tag = "R2";
    wr(4, 16'h0040); idle(3);
    chk(irq_req == 0, "R2 prio0", irq_req, 0);
    wr(0, 16'h0040); wr(4, 0);
    // R4 arbitration
    cur_tag = "R4";
    wr(8, 16'h4000); wr(10, 16'h0400); wr(13, 16'h0006);
    wr(4, 16'h0408); wr(5, 16'h0010);
    @(negedge clk); src_evt[3] = 1; src_evt[10] = 1; src_evt[20] = 1;
    @(negedge clk); src_evt = '0;
    idle(2);
    chk(irq_req == 1 && irq_vec == 28 && irq_lvl == 6, "R4 highest", irq_vec, 28);
    // R6 acknowledge
    cur_tag = "R6";
    pulse_ack();
    rd(21, v); chk(v == 6, "R6 level", v, 6);
    rd(22, v); chk(v == 16'h061C, "R6 status", v, 16'h061C);
    // R7 return
    cur_tag = "R7";
    pulse_ret(); rd(21, v); chk(v == 0, "R7 restore", v, 0);
    pulse_ret(); rd(21, v); chk(v == 0, "R7 empty", v, 0);
    cur_tag = "R4";
    wr(1, 16'h0010); idle(2);
    chk(irq_req == 1 && irq_vec == 11, "R4 tie", irq_vec, 11);
    // R3 level compare
    cur_tag = "R3";
    wr(21, 4); idle(2); chk(irq_req == 0, "R3 not above", irq_req, 0);
    wr(21, 3); idle(2); chk(irq_req == 1 && irq_lvl == 4, "R3 above", irq_lvl, 4);
    wr(21, 0);
    // R8 nesting disable
    cur_tag = "R8";
    wr(20, 16'h8000); idle(1);
    pulse_ack(); evt(20); idle(2);
    chk(irq_req == 0, "R8 blocked", irq_req, 0);
    wr(21, 0); rd(21, v); chk(v == 4, "R8 locked", v, 4);
    // R5 exception bypasses nesting
    cur_tag = "R5";
    @(negedge clk); trap_evt[1] = 1;
    @(negedge clk); trap_evt = '0;
    idle(1);
    chk(irq_req == 1 && irq_vec == 1 && irq_lvl == 14, "R5 trap", irq_vec, 1);
    pulse_ack(); rd(3, v); chk(v == 0, "R5 cleared", v, 0);
    pulse_ret(); pulse_ret();
    wr(20, 0); idle(2);
    // R9 masking window
    cur_tag = "R9";
    wr(23, 3); idle(2);
    chk(irq_req == 0, "R9 masked", irq_req, 0);
    rd(20, v); chk(v == 16'h4000, "R9 status", v, 16'h4000);
    wr(15, 16'h0700); wr(5, 16'h4010); evt(30); idle(1);
    chk(irq_req == 1 && irq_vec == 38 && irq_lvl == 7, "R9 prio7", irq_vec, 38);
    wr(1, 16'h4000);
    for (int n = 0; n < 3; n++) begin
      @(negedge clk); instr_retire = 1;
      @(negedge clk); instr_retire = 0;
    end
    idle(1);
    chk(irq_req == 1 && irq_vec == 28, "R9 ends", irq_vec, 28);
    rd(20, v); chk(v == 0, "R9 status off", v, 0);
    // R10 alternate table
    cur_tag = "R10";
    wr(20, 16'h2000); idle(1);
    chk(irq_alt == 1, "R10 alt", irq_alt, 1);
    wr(20, 0); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule